// File: doc/BRIEF.md
# Mantissa Normalize and Round Unit

This unit takes a raw two's-complement working mantissa from a floating-point datapath and finishes it. The mantissa may be unnormalized, and it comes with a pending exponent and a sticky flag that records bits lost in earlier shifts. The unit first clears the low bits that the chosen precision could not have kept. It then shifts left until the mantissa is normalized, lowering the exponent once for each shift. Last, it folds in the sticky flag and rounds to a 24-, 40- or 56-bit result. The rounding constant depends on the sign, so negative values round differently from positive ones.

A caller pulses `start_i` with all operands valid, waits while `busy_o` is high, and takes the result in the cycle that `done_o` pulses. Normalization advances one bit per cycle, so the latency depends on the operand. A positive mantissa that carries out of its sign bit during rounding is shifted back right by one, its exponent is raised, and the event is flagged.

Top module: `mant_norm_round`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `busy_o`, `rnd_ovf_o`, `mant_o` and `exp_o` are all zero until the first result arrives.
- R2: Precision code 00 keeps 24 result bits, 01 keeps 40, and 10 or 11 keep 56. Before normalizing, the mantissa is cut to its upper 56 bits for codes 00/01 and to its upper 60 bits for codes 10/11, and zeros enter from the right during shifts.
- R3: Normalization shifts left until bit 63 differs from bit 62. The output exponent is the input exponent minus the number of shifts.
- R4: A mantissa that is zero after the cut gives `mant_o` = 0, `exp_o` = 0 and `rnd_ovf_o` = 0, whatever the sticky flag is.
- R5: Rounding adds a constant to the eight bits just below the result LSB, which are bits 39..32, 23..16 or 7..0 for 24, 40 or 56 result bits. The constant is 0x80 when bit 63 is 0 and 0x7F when bit 63 is 1. The guard bit is the top bit of that field after normalization.
- R6: The sticky flag is ORed into bit 0 of the normalized mantissa before the rounding add.
- R7: If the add turns a non-negative mantissa negative, the sum is shifted right by one with a zero entering bit 63, the exponent is raised by one, and `rnd_ovf_o` is 1. In every other case `rnd_ovf_o` is 0.
- R8: All bits of `mant_o` below the result LSB are zero.
- R9: `done_o` is a one-cycle pulse, n+3 rising edges after the edge that samples `start_i` (counting that edge), where n is the number of normalizing shifts. `busy_o` is high from that edge until `done_o` rises, and low while `done_o` is high.
- R10: `start_i` is ignored while `busy_o` is high. The running operation's result is unchanged, and no second result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Accept operands when idle |
| mant_i | input | 64 | Two's-complement working mantissa, bit 63 is the sign |
| prec_i | input | 2 | Precision code (00 single, 01 extended, 10/11 double) |
| sticky_i | input | 1 | Sticky flag from earlier shifts |
| exp_i | input | 16 | Signed exponent |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| mant_o | output | 64 | Rounded, normalized mantissa |
| exp_o | output | 16 | Adjusted signed exponent |
| rnd_ovf_o | output | 1 | Rounding carried out of the sign |

## Verification
The bench aims at exact ties in both signs. A design that ignored the sign, or added a one at the guard position, would send a negative tie such as 0xA000_0080_0000_0000 upward instead of truncating it. It drives low-only operands that the cut must erase; a design that skipped the cut would normalize garbage bits into a nonzero result with a very negative exponent. A negative double-precision tie with sticky set must round up through bit 8, which shows that sticky is folded in before the add. An all-ones single mantissa must overflow back to 0x4000… with the exponent raised. Cycle counts, a start pulse sent mid-operation and random operands in every code complete the coverage.

// File: rtl/mnr_pkg.sv
package mnr_pkg;
    localparam int MW        = 64;
    localparam int EXP_W     = 16;
    localparam int SGL_BITS  = 24;
    localparam int EXT_BITS  = 40;
    localparam int DBL_BITS  = 56;
    localparam int CUT_NARROW = 56;
    localparam int CUT_WIDE   = 60;
    localparam int RND_W     = 8;

    typedef enum logic [1:0] {
        PREC_SGL     = 2'b00,
        PREC_EXT     = 2'b01,
        PREC_DBL     = 2'b10,
        PREC_DBL_ALT = 2'b11
    } prec_e;

    typedef enum logic [1:0] {
        NS_IDLE  = 2'b00,
        NS_SHIFT = 2'b01,
        NS_HAND  = 2'b10
    } nstate_e;

    typedef logic [MW-1:0]           mant_t;
    typedef logic signed [EXP_W-1:0] exp_t;

    typedef struct packed {
        mant_t mant;
        exp_t  exp;
        logic  sticky;
        prec_e prec;
    } work_t;

    typedef struct packed {
        mant_t mant;
        exp_t  exp;
        logic  ovf;
    } res_t;

    function automatic int res_bits(prec_e p);
        case (p)
            PREC_SGL: return SGL_BITS;
            PREC_EXT: return EXT_BITS;
            default:  return DBL_BITS;
        endcase
    endfunction

    function automatic mant_t top_mask(int n);
        mant_t ones;
        ones = '1;
        return ones << (MW - n);
    endfunction

    function automatic mant_t cut_mask(prec_e p);
        return top_mask((p == PREC_SGL || p == PREC_EXT) ? CUT_NARROW : CUT_WIDE);
    endfunction

    function automatic mant_t keep_mask(prec_e p);
        return top_mask(res_bits(p));
    endfunction

    function automatic mant_t rnd_const(prec_e p, logic neg);
        mant_t c;
        c = neg ? mant_t'(8'h7F) : mant_t'(8'h80);
        return c << (MW - RND_W - res_bits(p));
    endfunction
endpackage

// File: rtl/mnr_premask.sv
module mnr_premask
    import mnr_pkg::*;
(
    input  mant_t mant_i,
    input  prec_e prec_i,
    output mant_t mant_o
);
    always_comb begin
        mant_o = mant_i & cut_mask(prec_i);
    end
endmodule

// File: rtl/mnr_normalizer.sv
module mnr_normalizer
    import mnr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  work_t load_i,
    output logic  busy_o,
    output logic  hand_o,
    output work_t work_o
);
    nstate_e state_q;
    work_t   w_q;
    logic    settled;

    always_comb begin
        settled = (w_q.mant == '0) || (w_q.mant[MW-1] != w_q.mant[MW-2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= NS_IDLE;
            w_q     <= '0;
        end else begin
            case (state_q)
                NS_IDLE: begin
                    if (start_i) begin
                        w_q     <= load_i;
                        state_q <= NS_SHIFT;
                    end
                end
                NS_SHIFT: begin
                    if (settled) begin
                        state_q <= NS_HAND;
                    end else begin
                        w_q.mant <= w_q.mant << 1;
                        w_q.exp  <= w_q.exp - exp_t'(1);
                    end
                end
                default: state_q <= NS_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != NS_IDLE);
    assign hand_o = (state_q == NS_HAND);
    assign work_o = w_q;

    // R3: a handed-off mantissa is normalized or zero
    p_handoff_norm_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == NS_HAND) |-> ((w_q.mant == '0) || (w_q.mant[MW-1] ^ w_q.mant[MW-2])));

    // R10: operands captured at start stay put while busy
    p_hold_operands_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != NS_IDLE) |=> ($stable(w_q.sticky) && $stable(w_q.prec)));

    // R3: each shift step lowers the exponent by exactly one
    p_shift_exp_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == NS_SHIFT && !settled) |=> (w_q.exp == $past(w_q.exp) - exp_t'(1)));
endmodule

// File: rtl/mnr_rounder.sv
module mnr_rounder
    import mnr_pkg::*;
(
    input  work_t work_i,
    output res_t  res_o
);
    logic  is_zero;
    logic  neg;
    logic  carry_sign;
    mant_t folded;
    mant_t sum;
    mant_t adj;

    always_comb begin
        is_zero    = (work_i.mant == '0);
        neg        = work_i.mant[MW-1];
        folded     = work_i.mant | mant_t'(work_i.sticky);
        sum        = folded + rnd_const(work_i.prec, neg);
        carry_sign = !neg && sum[MW-1];
        adj        = carry_sign ? (sum >> 1) : sum;
        if (is_zero) begin
            res_o = '0;
        end else begin
            res_o.mant = adj & keep_mask(work_i.prec);
            res_o.exp  = carry_sign ? (work_i.exp + exp_t'(1)) : work_i.exp;
            res_o.ovf  = carry_sign;
        end
    end
endmodule

// File: rtl/mant_norm_round.sv
module mant_norm_round
    import mnr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [63:0]             mant_i,
    input  logic [1:0]              prec_i,
    input  logic                    sticky_i,
    input  logic signed [15:0]      exp_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [63:0]             mant_o,
    output logic signed [15:0]      exp_o,
    output logic                    rnd_ovf_o
);
    prec_e prec_in;
    mant_t cut_mant;
    work_t load_w;
    work_t norm_w;
    logic  hand;
    res_t  res;
    prec_e prec_q;

    assign prec_in = prec_e'(prec_i);

    mnr_premask u_cut (
        .mant_i (mant_i),
        .prec_i (prec_in),
        .mant_o (cut_mant)
    );

    always_comb begin
        load_w.mant   = cut_mant;
        load_w.exp    = exp_i;
        load_w.sticky = sticky_i;
        load_w.prec   = prec_in;
    end

    mnr_normalizer u_norm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_i  (load_w),
        .busy_o  (busy_o),
        .hand_o  (hand),
        .work_o  (norm_w)
    );

    mnr_rounder u_rnd (
        .work_i (norm_w),
        .res_o  (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            mant_o    <= '0;
            exp_o     <= '0;
            rnd_ovf_o <= 1'b0;
            prec_q    <= PREC_SGL;
        end else begin
            done_o <= hand;
            if (hand) begin
                mant_o    <= res.mant;
                exp_o     <= res.exp;
                rnd_ovf_o <= res.ovf;
                prec_q    <= norm_w.prec;
            end
        end
    end

    // R9: the result strobe lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: the unit is idle while presenting a result
    p_idle_at_done_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R4: a zero mantissa carries a zero exponent
    p_zero_exp_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && mant_o == '0) |-> (exp_o == '0 && !rnd_ovf_o));

    // R8: nothing below the result LSB survives
    p_low_clear_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((mant_o & ~keep_mask(prec_q)) == '0));

    // R7: a rounding carry leaves the mantissa as 01 followed by zeros in the top bits
    p_ovf_shape_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && rnd_ovf_o) |-> (mant_o[63:62] == 2'b01));
endmodule

// File: tb/tb_mant_norm_round.sv
module tb_mant_norm_round;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst;
    logic               start_i;
    logic [63:0]        mant_i;
    logic [1:0]         prec_i;
    logic               sticky_i;
    logic signed [15:0] exp_i;
    logic               busy_o;
    logic               done_o;
    logic [63:0]        mant_o;
    logic signed [15:0] exp_o;
    logic               rnd_ovf_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mant_norm_round dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .mant_i    (mant_i),
        .prec_i    (prec_i),
        .sticky_i  (sticky_i),
        .exp_i     (exp_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .mant_o    (mant_o),
        .exp_o     (exp_o),
        .rnd_ovf_o (rnd_ovf_o)
    );

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference from the requirements text
    task automatic ref_model(input logic [63:0] mi, input logic [1:0] p, input logic st,
                             input logic signed [15:0] ei, output logic [63:0] mo,
                             output logic signed [15:0] eo, output logic ov, output int n);
        int w;
        int cutn;
        logic [63:0] m;
        logic [63:0] s;
        logic [63:0] c;
        logic        ng;
        w    = (p == 2'b00) ? 24 : (p == 2'b01) ? 40 : 56;
        cutn = (p[1]) ? 60 : 56;
        m    = mi & ({64{1'b1}} << (64 - cutn));
        eo   = ei;
        n    = 0;
        if (m != 64'd0) begin
            while (m[63] == m[62]) begin
                m  = m << 1;
                eo = eo - 16'sd1;
                n++;
            end
        end
        ov = 1'b0;
        if (m == 64'd0) begin
            mo = 64'd0;
            eo = 16'sd0;
        end else begin
            ng = m[63];
            c  = (ng ? 64'h7F : 64'h80) << (56 - w);
            s  = (m | {63'd0, st}) + c;
            if (!ng && s[63]) begin
                ov = 1'b1;
                s  = s >> 1;
                eo = eo + 16'sd1;
            end
            mo = s & ({64{1'b1}} << (64 - w));
        end
    endtask

    task automatic run_op(string tag, logic [63:0] mi, logic [1:0] p, logic st,
                          logic signed [15:0] ei);
        logic [63:0]        em;
        logic signed [15:0] ee;
        logic               eov;
        int                 n;
        int                 edges;
        ref_model(mi, p, st, ei, em, ee, eov, n);
        @(negedge clk);
        start_i  = 1'b1;
        mant_i   = mi;
        prec_i   = p;
        sticky_i = st;
        exp_i    = ei;
        @(negedge clk);
        start_i = 1'b0;
        edges   = 1;
        while (!done_o && edges < 200) begin
            @(negedge clk);
            edges++;
        end
        check(tag, "latency", 64'(edges), 64'(n + 3));
        check(tag, "mant", mant_o, em);
        check(tag, "exp", 64'(exp_o), 64'(ee));
        check(tag, "ovf", 64'(rnd_ovf_o), 64'(eov));
    endtask

    task automatic t_reset();
        check("R1", "done", 64'(done_o), 64'd0);
        check("R1", "busy", 64'(busy_o), 64'd0);
        check("R1", "mant", mant_o, 64'd0);
        check("R1", "exp", 64'(exp_o), 64'd0);
        check("R1", "ovf", 64'(rnd_ovf_o), 64'd0);
    endtask

    task automatic t_masking();
        run_op("R2 single cut", 64'h0000_0000_0000_00FF, 2'b00, 1'b0, 16'sd5);
        check("R2", "single cut to zero", mant_o, 64'd0);
        run_op("R2 ext cut", 64'h0000_0000_0000_0080, 2'b01, 1'b1, 16'sd7);
        check("R2", "ext cut exp", 64'(exp_o), 64'd0);
        run_op("R2 double cut", 64'h0000_0000_0000_000F, 2'b10, 1'b0, 16'sd3);
        check("R2", "double cut to zero", mant_o, 64'd0);
        run_op("R2 double keeps bit4", 64'h0000_0000_0000_0010, 2'b10, 1'b0, 16'sd100);
        check("R2", "double bit4 mant", mant_o, 64'h4000_0000_0000_0000);
        check("R3", "double bit4 exp", 64'(exp_o), 64'(16'sd42));
    endtask

    task automatic t_zero();
        run_op("R4 zero sticky", 64'd0, 2'b10, 1'b1, -16'sd9);
        check("R4", "zero exp", 64'(exp_o), 64'd0);
    endtask

    task automatic t_ties();
        run_op("R5 pos tie", 64'h4000_0080_0000_0000, 2'b00, 1'b0, 16'sd1);
        check("R5", "pos tie up", mant_o, 64'h4000_0100_0000_0000);
        run_op("R5 neg tie", 64'hA000_0080_0000_0000, 2'b00, 1'b0, 16'sd1);
        check("R5", "neg tie down", mant_o, 64'hA000_0000_0000_0000);
        run_op("R5 ext neg", 64'hB123_4567_89AB_CDEF, 2'b01, 1'b0, -16'sd4);
        run_op("R3 deep neg", 64'hFFFF_FFF0_0000_0000, 2'b01, 1'b0, 16'sd0);
    endtask

    task automatic t_sticky();
        run_op("R6 no sticky", 64'hA000_0000_0000_0080, 2'b10, 1'b0, 16'sd2);
        check("R6", "neg dbl no sticky", mant_o, 64'hA000_0000_0000_0000);
        run_op("R6 sticky", 64'hA000_0000_0000_0080, 2'b11, 1'b1, 16'sd2);
        check("R6", "neg dbl sticky", mant_o, 64'hA000_0000_0000_0100);
    endtask

    task automatic t_overflow();
        run_op("R7 carry", 64'h7FFF_FF80_0000_0000, 2'b00, 1'b0, 16'sd10);
        check("R7", "carry mant", mant_o, 64'h4000_0000_0000_0000);
        check("R7", "carry exp", 64'(exp_o), 64'(16'sd11));
        check("R7", "carry flag", 64'(rnd_ovf_o), 64'd1);
        run_op("R8 low clear", 64'h5555_5555_5555_5555, 2'b01, 1'b1, 16'sd0);
    endtask

    task automatic t_busy_ignore();
        int edges;
        @(negedge clk);
        start_i  = 1'b1;
        mant_i   = 64'h0000_0000_0000_0010;
        prec_i   = 2'b10;
        sticky_i = 1'b0;
        exp_i    = 16'sd0;
        @(negedge clk);
        start_i = 1'b0;
        edges   = 1;
        repeat (4) begin
            @(negedge clk);
            edges++;
        end
        check("R9", "busy mid op", 64'(busy_o), 64'd1);
        start_i  = 1'b1;
        mant_i   = 64'h7FFF_FF80_0000_0000;
        prec_i   = 2'b00;
        sticky_i = 1'b1;
        exp_i    = 16'sd50;
        @(negedge clk);
        start_i = 1'b0;
        edges++;
        while (!done_o && edges < 200) begin
            @(negedge clk);
            edges++;
        end
        check("R10", "latency", 64'(edges), 64'd61);
        check("R10", "mant", mant_o, 64'h4000_0000_0000_0000);
        check("R10", "exp", 64'(exp_o), 64'(-16'sd58));
        repeat (4) @(negedge clk);
        check("R10", "no second result busy", 64'(busy_o), 64'd0);
        check("R10", "no second result done", 64'(done_o), 64'd0);
    endtask

    task automatic t_random();
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 20; k++) begin
                logic [63:0] r;
                logic signed [63:0] rs;
                r  = {$urandom, $urandom};
                rs = $signed(r) >>> ($urandom % 48);
                if (k % 5 == 0) rs[38:0] = 39'h40_0000_0000 >> (((p == 0) ? 0 : (p == 1) ? 16 : 32));
                run_op("R5 random", rs, 2'(p), 1'($urandom % 2), 16'($urandom % 200) - 16'sd100);
            end
        end
    endtask

    initial begin
        rst      = 1'b1;
        start_i  = 1'b0;
        mant_i   = '0;
        prec_i   = '0;
        sticky_i = 1'b0;
        exp_i    = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_masking();
        t_zero();
        t_ties();
        t_sticky();
        t_overflow();
        t_busy_ignore();
        t_random();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule